// File: doc/BRIEF.md
# Dual-Clock FIFO with Combined Flags

This block is a first-in first-out buffer that keeps its own write and read pointers and derives all of its status flags internally, so no logic outside it is needed to run it. Data is written on the write clock and read on the read clock. The two clocks may be the same net or may run with no fixed relation to each other. Pointers cross between the domains as Gray codes through two-flop synchronisers.

Three flags are provided. An active-low combined flag goes low when the buffer is empty (seen from the read side) or full (seen from the write side). A half flag is raised once the stored count reaches half the depth. An almost flag is raised when the count is near either end, with the margin set by a threshold input. Writes into a full buffer and reads from an empty buffer are dropped.

The default geometry is 1024 entries of 8 bits.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is applied and after it is released with no writes, `flag_ef_n` is 0, `flag_hf` is 0, `flag_af` is 1 and `rd_data` is 0.
- R2: Words are returned on `rd_data` in the order they were written; a read accepted at a read-clock edge presents its word on `rd_data` right after that edge.
- R3: A write while the buffer is full is dropped: the stored words and the count are unchanged.
- R4: A read while the buffer is empty is dropped: `rd_data` holds its value and the read pointer does not move.
- R5: `flag_ef_n` is 0 when the buffer is empty or full (count 0 or DEPTH) and 1 for any count in between.
- R6: `flag_hf` is 1 exactly when the count is at least DEPTH/2, and the count never exceeds DEPTH.
- R7: `flag_af` is 1 exactly when the count is at most `af_thresh` or at least DEPTH minus `af_thresh`.
- R8: A read and a write in the same cycle are both performed when the buffer is neither empty nor full.
- R9: With unrelated write and read clocks every written word is read back once, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock (may be tied to wr_clk) |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered output word |
| af_thresh | input | AW | Margin for the almost flag |
| flag_ef_n | output | 1 | Active-low empty-or-full flag |
| flag_hf | output | 1 | Half-full flag |
| flag_af | output | 1 | Almost-empty-or-almost-full flag |

## Verification
On every cycle the assertions check that a write into a full buffer and a read from an empty one leave the pointer (and the output word) unchanged, that an accepted write moves the pointer by exactly one, that the count never exceeds the depth, and that full always coincides with the half and almost flags and a low combined flag. Only the bench scenarios can show data order across fill, overflow, drain and underflow, the exact flag values at chosen counts and thresholds, simultaneous read and write, transfer between unrelated clocks, and a reset in mid-stream.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Gray to binary over a 32-bit container; callers zero-extend and truncate.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_thresh,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          wr_fire,
  output logic [AW:0]   wcount,
  output logic          hf,
  output logic          af
);
  import dcf_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] HALF_C  = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [AW:0] wbin_d, wgray_d, rbin_s;

  // next state
  always_comb begin
    wr_fire = wr_en & ~full;
    wbin_d  = wbin + (AW+1)'(wr_fire);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  // registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_d;
      wgray <= wgray_d;
    end
  end

  // status in the write domain
  always_comb begin
    full   = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    rbin_s = (AW+1)'(gray_to_bin(32'(rgray_s)));
    wcount = wbin - rbin_s;
    hf     = (wcount >= HALF_C);
    af     = (wcount <= {1'b0, af_thresh}) ||
             (wcount >= (DEPTH_C - {1'b0, af_thresh}));
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [AW:0] wgray_s,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray,
  output logic        empty,
  output logic        rd_fire
);
  logic [AW:0] rbin_d, rgray_d;

  always_comb begin
    empty   = (rgray == wgray_s);
    rd_fire = rd_en & ~empty;
    rbin_d  = rbin + (AW+1)'(rd_fire);
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_d;
      rgray <= rgray_d;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= store[raddr];
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] af_thresh,
  output logic          flag_ef_n,
  output logic          flag_hf,
  output logic          flag_af
);
  logic          wrst_n, rrst_n;
  logic [AW:0]   wbin, wgray, rbin, rgray, wgray_s, rgray_s, wcount;
  logic          w_full, r_empty, wr_fire, rd_fire;

  // per-domain reset: asserted at once, released on the domain's clock
  dcf_sync #(.W(1)) u_wrst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  dcf_sync #(.W(1)) u_rrst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  // Gray pointer crossings
  dcf_sync #(.W(AW+1)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(AW+1)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .af_thresh(af_thresh), .wbin(wbin), .wgray(wgray), .full(w_full),
    .wr_fire(wr_fire), .wcount(wcount), .hf(flag_hf), .af(flag_af)
  );

  dcf_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .rbin(rbin), .rgray(rgray), .empty(r_empty), .rd_fire(rd_fire)
  );

  dcf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wr_clk(wr_clk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rrst_n), .re(rd_fire), .raddr(rbin[AW-1:0]),
    .rdata(rd_data)
  );

  // combined flag: empty from the read side, full from the write side
  assign flag_ef_n = ~(r_empty | w_full);
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          w_full,
  input logic          r_empty,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wcount,
  input logic [DW-1:0] rd_data,
  input logic          flag_ef_n,
  input logic          flag_hf,
  input logic          flag_af
);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(1 << AW);

  a_r2_wptr_step: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_en && !w_full) |=> (wbin == $past(wbin) + (AW+1)'(1)));

  a_r3_full_blocks: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_en && w_full) |=> $stable(wbin));

  a_r4_empty_blocks: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_en && r_empty) |=> ($stable(rbin) && $stable(rd_data)));

  a_r5_low_when_full: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    w_full |-> !flag_ef_n);

  a_r6_count_bound: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wcount <= DEPTH_C);

  a_r6_half_when_full: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    w_full |-> flag_hf);

  a_r7_almost_when_full: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    w_full |-> flag_af);
endmodule

bind dcf_fifo dcf_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_en(wr_en), .rd_en(rd_en), .w_full(w_full), .r_empty(r_empty),
  .wbin(wbin), .rbin(rbin), .wcount(wcount), .rd_data(rd_data),
  .flag_ef_n(flag_ef_n), .flag_hf(flag_hf), .flag_af(flag_af)
);

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  // columns: writes, reads, threshold, exp ef_n, exp hf, exp af
  localparam int NV = 10;
  localparam int VEC [NV][6] = '{
    '{3, 0, 2, 1, 0, 0},   // count 3
    '{5, 0, 2, 1, 1, 0},   // count 8
    '{0, 0, 8, 1, 1, 1},   // count 8, low margin reached
    '{6, 0, 3, 1, 1, 1},   // count 14, high margin reached
    '{2, 0, 3, 0, 1, 1},   // count 16 full
    '{3, 0, 3, 0, 1, 1},   // overflow dropped
    '{0, 9, 3, 1, 0, 0},   // count 7
    '{0, 7, 0, 0, 0, 1},   // count 0 empty
    '{0, 2, 0, 0, 0, 1},   // underflow dropped
    '{1, 0, 1, 1, 0, 1}    // count 1
  };

  logic clk, rclk, rst_n;
  logic wr_en, rd_en, a_wr_en, a_rd_en;
  logic [DW-1:0] wr_data, a_wr_data, rd_data, a_rd_data;
  logic [AW-1:0] thresh;
  logic ef_n, hf, af, a_ef_n, a_hf, a_af;

  int checks, fails;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] aq[$];
  logic [DW-1:0] seq;

  dcf_fifo #(.AW(AW), .DW(DW)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .af_thresh(thresh),
    .flag_ef_n(ef_n), .flag_hf(hf), .flag_af(af)
  );

  dcf_fifo #(.AW(AW), .DW(DW)) dut_async_i (
    .wr_clk(clk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_data(a_wr_data),
    .rd_en(a_rd_en), .rd_data(a_rd_data), .af_thresh(thresh),
    .flag_ef_n(a_ef_n), .flag_hf(a_hf), .flag_af(a_af)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;           // 125 MHz
  initial rclk = 1'b0;
  always #5.5 rclk = ~rclk;        // unrelated read clock

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (mq.size() < DEPTH) mq.push_back(d);
  endtask

  task automatic rd1(input string req);
    logic [DW-1:0] prev;
    @(negedge clk);
    rd_en = 1'b1;
    prev = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    if (mq.size() > 0) begin
      logic [DW-1:0] e;
      e = mq.pop_front();
      check(rd_data == e, req, rd_data, e);
    end else begin
      check(rd_data == prev, "R4 read when empty", rd_data, prev);
    end
  endtask

  task automatic flags(input string req, input int e_ef, input int e_hf, input int e_af);
    repeat (5) @(negedge clk);
    check(ef_n == e_ef[0], {req, " R5 flag_ef_n"}, ef_n, e_ef);
    check(hf == e_hf[0], {req, " R6 flag_hf"}, hf, e_hf);
    check(af == e_af[0], {req, " R7 flag_af"}, af, e_af);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    mq.delete();
    aq.delete();
    check(ef_n == 1'b0 && hf == 1'b0 && af == 1'b1, "R1 flags in reset",
          {ef_n, hf, af}, 3'b001);
    check(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; seq = 8'h10;
    wr_en = 0; rd_en = 0; wr_data = '0; thresh = '0;
    a_wr_en = 0; a_rd_en = 0; a_wr_data = '0;
    rst_n = 1'b0;
    do_reset();
    flags("R1 after release", 0, 0, 1);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      thresh = AW'(VEC[i][2]);
      for (int k = 0; k < VEC[i][0]; k++) begin
        wr1(seq);
        seq = seq + 8'd1;
      end
      for (int k = 0; k < VEC[i][1]; k++) rd1("R2 order");
      flags($sformatf("vec%0d", i), VEC[i][3], VEC[i][4], VEC[i][5]);
    end

    // R8: simultaneous read and write with 4 stored
    thresh = '0;
    for (int k = 0; k < 3; k++) begin
      wr1(seq);
      seq = seq + 8'd1;
    end
    repeat (4) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      logic [DW-1:0] e;
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1; wr_data = seq;
      e = mq.pop_front();
      mq.push_back(seq);
      seq = seq + 8'd1;
      @(posedge clk);
      #1;
      check(rd_data == e, "R8 same-cycle read data", rd_data, e);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    flags("R8 count kept at 4", 1, 0, 0);
    for (int k = 0; k < 4; k++) rd1("R8 drain order");
    flags("R8 drained", 0, 0, 1);

    // R9: unrelated clocks
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      a_wr_en = 1'b1; a_wr_data = 8'hA0 + 8'(k);
      aq.push_back(8'hA0 + 8'(k));
    end
    @(negedge clk);
    a_wr_en = 1'b0;
    repeat (8) @(negedge clk);
    check(a_ef_n == 1'b1, "R9 not empty after writes", a_ef_n, 1);
    for (int k = 0; k < 10; k++) begin
      logic [DW-1:0] e;
      @(negedge rclk);
      a_rd_en = 1'b1;
      @(negedge rclk);
      a_rd_en = 1'b0;
      e = aq.pop_front();
      check(a_rd_data == e, "R9 cross-clock order", a_rd_data, e);
      repeat (2) @(negedge rclk);
    end
    repeat (8) @(negedge clk);
    check(a_ef_n == 1'b0, "R9 empty after drain", a_ef_n, 0);

    // R1: reset in mid-stream
    for (int k = 0; k < 5; k++) begin
      wr1(seq);
      seq = seq + 8'd1;
    end
    do_reset();
    flags("R1 mid-stream reset", 0, 0, 1);
    rd1("R4 read after reset");
    check(rd_data == '0, "R4 rd_data after empty read", rd_data, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule